// File: doc/BRIEF.md
# Accumulator Carry PWM Bank

The block is a bank of four pulse-density modulators. Each channel keeps an 8-bit level that a host may load at any moment, and a private 8-bit phase accumulator. On every cycle in which the external enable tick is high, each channel adds its level into its accumulator, wrapping modulo 256. The carry out of that addition becomes the channel's output bit for that tick. A level of L therefore yields L high ticks in every window of 256 ticks, and those high ticks are spread as evenly as the arithmetic allows. They are not grouped at the start of a fixed period.

A fresh carry vector is built on every tick. All four bits are then loaded into one output register at the same clock edge, so the outputs never change one at a time. The outputs keep their value between ticks. Level writes use a channel select, a data byte and a strobe. A write never disturbs the running accumulator.

Top module: `pdm_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every level, every accumulator and `pwm_out` to zero. After reset, and with no writes, every tick leaves `pwm_out` at 0.
- R2: On a cycle with `tick` high, each channel's accumulator takes the value (accumulator + level) mod 256. With `tick` low the accumulator is unchanged.
- R3: A tick drives the channel's output bit to the carry out of that 9-bit addition. Channel i appears on `pwm_out[i]` one clock after the tick.
- R4: `pwm_out` changes only one clock after a tick, and all four bits are loaded at the same edge. With `tick` low the register holds its value.
- R5: A channel with level 0 never drives its output high.
- R6: A channel with level 255 drives its output high on exactly 255 of any 256 consecutive ticks.
- R7: A level write takes effect from the first tick after the write cycle; a tick in the same cycle as the write still uses the old level. A write does not reset the accumulator.
- R8: A write with `wr_en` high loads `wr_data` into the channel numbered `wr_sel` (0 to 3, binary) and into no other channel.
- R9: When `wr_en` is low, `wr_sel` and `wr_data` have no effect on any level.
- R10: Starting from a zero accumulator, a level L gives exactly L high output ticks over 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Enable tick; each high cycle advances every channel by one step |
| wr_en | input | 1 | Level write strobe |
| wr_sel | input | 2 | Channel number for the write |
| wr_data | input | 8 | Level value to write |
| pwm_out | output | 4 | Registered channel outputs, bit i for channel i |

## Verification
Several properties are checked on every cycle by the assertions:
- outputs and accumulators hold between ticks;
- a level of zero never carries;
- each carry matches a wrap of the accumulator;
- a write enable reaches at most one channel, and reaches none without the strobe;
- reset clears the outputs.

Other behaviour only shows over long stretches of ticks, so the directed scenarios cover it. These are the exact count of high ticks per 256 for levels 0, 64, 128 and 255; the old level still applying to a tick that coincides with a write; the accumulator phase surviving a level change; and the routing of a write to the selected channel alone.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    parameter int NUM_CH  = 4;
    parameter int LEVEL_W = 8;
endpackage

// File: rtl/pdm_wr_decode.sv
module pdm_wr_decode #(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [N-1:0]     ch_wr_en
);
    always_comb begin
        ch_wr_en = '0;
        if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                ch_wr_en[i] = (wr_sel == SEL_W'(i));
            end
        end
    end

    // R8: a write enable reaches at most one channel
    always_comb begin
        assert_one_target_R8: assert ($onehot0(ch_wr_en));
    end

    // R9: with no strobe, no channel is enabled
    always_comb begin
        if (!wr_en) begin
            assert_no_strobe_idle_R9: assert (ch_wr_en == '0);
        end
    end
endmodule

// File: rtl/pdm_channel.sv
module pdm_channel #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_data,
    output logic          carry_o
);
    typedef struct packed {
        logic [LW-1:0] level;
        logic [LW-1:0] acc;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [LW:0] sum;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, st_q.level};
        carry_o = sum[LW];
        st_d    = st_q;
        if (tick) begin
            st_d.acc = sum[LW-1:0];
        end
        if (wr_en) begin
            st_d.level = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the accumulator is frozen between ticks
    property p_acc_hold;
        @(posedge clk) disable iff (rst) !tick |=> $stable(st_q.acc);
    endproperty
    assert_acc_hold_R2: assert property (p_acc_hold);

    // R3: a carry is reported exactly when the accumulator wraps
    property p_carry_wrap;
        @(posedge clk) disable iff (rst)
            tick |=> ((st_q.acc < $past(st_q.acc)) == $past(carry_o));
    endproperty
    assert_carry_wrap_R3: assert property (p_carry_wrap);

    // R5: a zero level never carries
    property p_zero_level;
        @(posedge clk) disable iff (rst) (st_q.level == '0) |-> !carry_o;
    endproperty
    assert_zero_level_R5: assert property (p_zero_level);

    // R9: a level changes only when its channel is written
    property p_level_hold;
        @(posedge clk) disable iff (rst) !wr_en |=> $stable(st_q.level);
    endproperty
    assert_level_hold_R9: assert property (p_level_hold);
endmodule

// File: rtl/pdm_bank.sv
module pdm_bank
    import pdm_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int LW    = LEVEL_W,
    parameter int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [LW-1:0]    wr_data,
    output logic [N_CH-1:0]  pwm_out
);
    typedef struct packed {
        logic [N_CH-1:0] bits;
    } out_state_t;

    logic [N_CH-1:0] ch_wr_en;
    logic [N_CH-1:0] carry_vec;
    logic [N_CH-1:0] scratch;
    out_state_t      out_d, out_q;

    pdm_wr_decode #(.N(N_CH), .SEL_W(SEL_W)) u_dec (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .ch_wr_en (ch_wr_en)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pdm_channel #(.LW(LW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr_en   (ch_wr_en[g]),
            .wr_data (wr_data),
            .carry_o (carry_vec[g])
        );
    end

    always_comb begin
        scratch = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (carry_vec[i]) scratch[i] = 1'b1;
        end
        out_d = out_q;
        if (tick) begin
            out_d.bits = scratch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_out = out_q.bits;

    // R4: the output register holds between ticks
    property p_out_hold;
        @(posedge clk) disable iff (rst) !tick |=> $stable(pwm_out);
    endproperty
    assert_out_hold_R4: assert property (p_out_hold);

    // R1: reset leaves the outputs cleared
    property p_reset_clear;
        @(posedge clk) rst |=> (pwm_out == '0);
    endproperty
    assert_reset_clear_R1: assert property (p_reset_clear);
endmodule

// File: tb/sim_pdm_bank.sv
module sim_pdm_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_lvl [4];
    logic [7:0] m_acc [4];
    logic [3:0] m_out;

    always #4 clk = ~clk;

    pdm_bank u0 (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model, sample 2 ns after posedge
    task automatic cyc(input logic t, input logic we, input logic [1:0] s,
                       input logic [7:0] d, input string req);
        tick = t; wr_en = we; wr_sel = s; wr_data = d;
        if (t) begin
            for (int i = 0; i < 4; i++) begin
                logic [8:0] sm;
                sm = {1'b0, m_acc[i]} + {1'b0, m_lvl[i]};
                m_out[i] = sm[8];
                m_acc[i] = sm[7:0];
            end
        end
        if (we) m_lvl[s] = d;
        @(posedge clk);
        #2;
        check(pwm_out == m_out, req, pwm_out, m_out);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 0; wr_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_lvl[i] = '0;
            m_acc[i] = '0;
        end
        m_out = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check(pwm_out == 4'h0, "R1 reset", pwm_out, 0);
        for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0, "R1 idle tick");
    endtask

    task automatic t_no_strobe();
        do_reset();
        for (int k = 0; k < 4; k++) cyc(0, 0, 2'(k), 8'hFF, "R9 unstrobed data");
        for (int k = 0; k < 8; k++) begin
            cyc(1, 0, 2'(k), 8'hFF, "R9 ticks after unstrobed data");
            check(pwm_out == 4'h0, "R9 output stays low", pwm_out, 0);
        end
    endtask

    task automatic t_density();
        int ones [4];
        int exp_l [4];
        exp_l[0] = 0; exp_l[1] = 64; exp_l[2] = 128; exp_l[3] = 255;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, 2'(i), 8'(exp_l[i]), "R8 level load");
            ones[i] = 0;
        end
        for (int k = 0; k < 256; k++) begin
            cyc(1, 0, 0, 0, "R2 R3 tick step");
            for (int i = 0; i < 4; i++) ones[i] += int'(pwm_out[i]);
        end
        check(ones[0] == 0, "R5 level 0 count", ones[0], 0);
        check(ones[1] == 64, "R10 level 64 count", ones[1], 64);
        check(ones[2] == 128, "R10 level 128 count", ones[2], 128);
        check(ones[3] == 255, "R6 level 255 count", ones[3], 255);
    endtask

    task automatic t_hold();
        logic [3:0] snap;
        do_reset();
        cyc(0, 1, 1, 8'd200, "R8 load ch1");
        cyc(0, 1, 3, 8'd255, "R8 load ch3");
        cyc(1, 0, 0, 0, "R3 tick");
        cyc(1, 0, 0, 0, "R3 tick");
        snap = pwm_out;
        check(snap == 4'b1010, "R3 pattern before hold", snap, 4'b1010);
        for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 0, 0, "R4 no tick");
            check(pwm_out == snap, "R4 output held", pwm_out, snap);
        end
    endtask

    task automatic t_write_timing();
        do_reset();
        cyc(0, 1, 0, 8'd128, "R8 load ch0");
        cyc(1, 0, 0, 0, "R7 step acc 128");
        check(pwm_out[0] == 1'b0, "R7 first tick low", pwm_out[0], 0);
        cyc(1, 0, 0, 0, "R7 step wrap");
        check(pwm_out[0] == 1'b1, "R7 wrap high", pwm_out[0], 1);
        cyc(1, 0, 0, 0, "R7 step acc 128");
        cyc(1, 1, 0, 8'd192, "R7 tick with write uses old level");
        check(pwm_out[0] == 1'b1, "R7 old level carry", pwm_out[0], 1);
        cyc(1, 0, 0, 0, "R7 new level acc 192");
        check(pwm_out[0] == 1'b0, "R7 new level no carry", pwm_out[0], 0);
        cyc(1, 0, 0, 0, "R7 new level wraps");
        check(pwm_out[0] == 1'b1, "R7 acc kept across write", pwm_out[0], 1);
        check(pwm_out[3:1] == 3'b000, "R8 other channels untouched", pwm_out[3:1], 0);
    endtask

    task automatic t_select();
        do_reset();
        cyc(0, 1, 2, 8'd255, "R8 load ch2 only");
        for (int k = 0; k < 3; k++) begin
            cyc(1, 0, 0, 0, "R8 routed write");
            check(pwm_out == 4'b0000 || pwm_out == 4'b0100, "R8 only ch2 active",
                  pwm_out, 4'b0100);
        end
        cyc(1, 0, 0, 0, "R8 routed write");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_no_strobe();
        t_density();
        t_hold();
        t_write_timing();
        t_select();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule